// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses where each of the two execute-stage ALU operands comes from in a five-stage in-order pipeline. An operand can come from the value read out of the register file. It can also come from the result parked in the memory stage, or from the result parked in the writeback stage. The block compares each execute-stage source index against the destinations of the two older in-flight instructions. When more than one of them wrote the same register, the youngest one wins. Register zero is never bypassed.

Operands whose producer is three or more instructions older are not handled here. The register file is expected to pass a same-cycle write through to a read, so the block needs only two bypass paths. One hazard cannot be covered by bypassing: a load whose data is needed by the very next instruction. For that case the block compares the decode-stage sources, qualified by use flags, against the destination of a load now in execute. It then raises a one-cycle stall request toward decode. The surrounding pipeline owns the muxes, the register file, the ALU and the stall mechanics.

Top module: `ex_operand_bypass`

## Requirements
- R1: When an execute source index is nonzero, equals `memDest` and `memRegWrite` is high, that operand's select is 2'b10 (memory-stage result).
- R2: When an execute source index is nonzero, equals `wbDest`, `wbRegWrite` is high and R1 does not apply, that operand's select is 2'b01 (writeback result).
- R3: In every other case the select is 2'b00 (register file). This includes a source index of zero even when a later stage writes register zero, and a matching stage whose write enable is low. The value 2'b11 never appears.
- R4: When both the memory and the writeback stages match the same source, the memory-stage result is chosen (2'b10).
- R5: The two operand selects are computed independently. Operand A follows `exRs` and operand B follows `exRt` with identical rules, and neither is influenced by the other's index.
- R6: `loadUseStall` is high when `exIsLoad` and `exRegWrite` are high, `exDest` is nonzero, and a decode source whose use flag is set equals `exDest`.
- R7: `loadUseStall` stays low when the matching decode source's use flag is low, when the execute instruction is not a load, when `exRegWrite` is low, or when `exDest` is zero.
- R8: The stall output and the operand selects do not affect one another. A stall request and active bypass selects can be asserted together for unrelated instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRs | input | 5 | First source index of the execute-stage instruction |
| exRt | input | 5 | Second source index of the execute-stage instruction |
| memDest | input | 5 | Destination index of the memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbDest | input | 5 | Destination index of the writeback-stage instruction |
| wbRegWrite | input | 1 | Writeback-stage instruction writes a register |
| idRs | input | 5 | First source index of the decode-stage instruction |
| idRt | input | 5 | Second source index of the decode-stage instruction |
| idUseRs | input | 1 | Decode instruction actually reads its first source |
| idUseRt | input | 1 | Decode instruction actually reads its second source |
| exDest | input | 5 | Destination index of the execute-stage instruction |
| exRegWrite | input | 1 | Execute-stage instruction writes a register |
| exIsLoad | input | 1 | Execute-stage instruction is a load |
| fwdSelA | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 writeback |
| fwdSelB | output | 2 | Operand B source, same encoding as fwdSelA |
| loadUseStall | output | 1 | Request to hold decode for one cycle |

## Verification
Two functions can meet in the same cycle: a load-use stall aimed at the decode instruction, and active bypass selects for the execute instruction. A dedicated scenario places a load in execute whose destination matches a used decode source. At the same moment, the execute instruction's sources hit the memory and writeback destinations. That scenario is judged correct only when the stall and both expected select codes appear together. The case where both selects collide on the same register is also provoked, with both stages writing it, and the memory-stage code must win. An exhaustive sweep over small index sets and enable combinations compares both selects against a model built from the priority rules.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

  // Operand source codes seen by the execute-stage muxes
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } bypassSel_e;

  // Strobes from the match control to the select datapath, one per operand
  typedef struct packed {
    logic memHit;
    logic wbHit;
  } matchStrobe_t;

endpackage

// File: rtl/bypass_match_ctrl.sv
module bypass_match_ctrl
  import bypass_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][ADDR_W-1:0] srcIdx,
  input  logic [ADDR_W-1:0]              memDest,
  input  logic                           memRegWrite,
  input  logic [ADDR_W-1:0]              wbDest,
  input  logic                           wbRegWrite,
  output matchStrobe_t [NUM_SRC-1:0]     strobes
);

  localparam logic [ADDR_W-1:0] ZERO_REG = '0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    matchStrobe_t hit;
    always_comb begin
      hit.memHit = memRegWrite && (srcIdx[g] != ZERO_REG) && (srcIdx[g] == memDest);
      hit.wbHit  = wbRegWrite  && (srcIdx[g] != ZERO_REG) && (srcIdx[g] == wbDest);
    end
    assign strobes[g] = hit;
  end

endmodule

// File: rtl/bypass_sel_dp.sv
module bypass_sel_dp
  import bypass_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  matchStrobe_t [NUM_SRC-1:0] strobes,
  output logic [NUM_SRC-1:0][1:0]    sel
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSel
    bypassSel_e pick;
    // youngest definition first
    always_comb begin
      if (strobes[g].memHit)     pick = SEL_MEM;
      else if (strobes[g].wbHit) pick = SEL_WB;
      else                       pick = SEL_REGFILE;
    end
    assign sel[g] = pick;
  end

endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int ADDR_W  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][ADDR_W-1:0] decSrc,
  input  logic [NUM_SRC-1:0]             decUse,
  input  logic [ADDR_W-1:0]              exDest,
  input  logic                           exRegWrite,
  input  logic                           exIsLoad,
  output logic                           stall
);

  localparam logic [ADDR_W-1:0] ZERO_REG = '0;

  logic loadInEx;
  logic [NUM_SRC-1:0] srcHit;

  assign loadInEx = exIsLoad && exRegWrite && (exDest != ZERO_REG);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gHit
    assign srcHit[g] = loadInEx && decUse[g] && (decSrc[g] == exDest);
  end

  assign stall = |srcHit;

  // R6 / R7: a stall is only ever caused by a real load writing a nonzero register
  always_comb begin
    if (stall) begin
      assert_stall_needs_load_R7: assert (exIsLoad && exRegWrite && exDest != ZERO_REG)
        else $error("stall without a qualifying load in execute");
    end
  end

endmodule

// File: rtl/ex_operand_bypass.sv
module ex_operand_bypass
  import bypass_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] exRs,
  input  logic [ADDR_W-1:0] exRt,
  input  logic [ADDR_W-1:0] memDest,
  input  logic              memRegWrite,
  input  logic [ADDR_W-1:0] wbDest,
  input  logic              wbRegWrite,
  input  logic [ADDR_W-1:0] idRs,
  input  logic [ADDR_W-1:0] idRt,
  input  logic              idUseRs,
  input  logic              idUseRt,
  input  logic [ADDR_W-1:0] exDest,
  input  logic              exRegWrite,
  input  logic              exIsLoad,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic              loadUseStall
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][ADDR_W-1:0] exSrc;
  logic [NUM_SRC-1:0][ADDR_W-1:0] idSrc;
  logic [NUM_SRC-1:0]             idUse;
  matchStrobe_t [NUM_SRC-1:0]     strobes;
  logic [NUM_SRC-1:0][1:0]        sel;

  assign exSrc = {exRt, exRs};
  assign idSrc = {idRt, idRs};
  assign idUse = {idUseRt, idUseRs};

  bypass_match_ctrl #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) i_ctrl (
    .srcIdx      (exSrc),
    .memDest     (memDest),
    .memRegWrite (memRegWrite),
    .wbDest      (wbDest),
    .wbRegWrite  (wbRegWrite),
    .strobes     (strobes)
  );

  bypass_sel_dp #(.NUM_SRC(NUM_SRC)) i_dp (
    .strobes (strobes),
    .sel     (sel)
  );

  load_use_detect #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) i_hazard (
    .decSrc     (idSrc),
    .decUse     (idUse),
    .exDest     (exDest),
    .exRegWrite (exRegWrite),
    .exIsLoad   (exIsLoad),
    .stall      (loadUseStall)
  );

  assign fwdSelA = sel[0];
  assign fwdSelB = sel[1];

  // Port-level checks on the operand A select
  always_comb begin
    if (fwdSelA == 2'b10) begin
      assert_mem_fwd_valid_R1: assert (memRegWrite && exRs != '0 && exRs == memDest)
        else $error("operand A memory bypass without a matching writer");
    end
    if (fwdSelA == 2'b01) begin
      assert_wb_fwd_valid_R2: assert (wbRegWrite && exRs != '0 && exRs == wbDest)
        else $error("operand A writeback bypass without a matching writer");
      assert_mem_wins_R4: assert (!(memRegWrite && exRs == memDest))
        else $error("operand A took the older definition");
    end
    if (fwdSelA == 2'b00) begin
      assert_rf_when_no_hit_R3: assert (exRs == '0 ||
          !((memRegWrite && exRs == memDest) || (wbRegWrite && exRs == wbDest)))
        else $error("operand A missed a bypass");
    end
    assert_code_legal_R3: assert (fwdSelA != 2'b11 && fwdSelB != 2'b11)
      else $error("illegal select code");
  end

  // Operand B follows the same rules from its own index
  always_comb begin
    if (fwdSelB == 2'b10) begin
      assert_b_mem_fwd_R5: assert (memRegWrite && exRt != '0 && exRt == memDest)
        else $error("operand B memory bypass without a matching writer");
    end
    if (fwdSelB == 2'b01) begin
      assert_b_wb_fwd_R5: assert (wbRegWrite && exRt != '0 && exRt == wbDest &&
          !(memRegWrite && exRt == memDest))
        else $error("operand B writeback bypass is wrong");
    end
  end

endmodule

// File: tb/test_ex_operand_bypass.sv
module test_ex_operand_bypass;

  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [AW-1:0] exRs, exRt, memDest, wbDest, idRs, idRt, exDest;
  logic memRegWrite, wbRegWrite, idUseRs, idUseRt, exRegWrite, exIsLoad;
  logic [1:0] fwdSelA, fwdSelB;
  logic loadUseStall;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  ex_operand_bypass #(.ADDR_W(AW)) i_ex_operand_bypass (
    .exRs(exRs), .exRt(exRt), .memDest(memDest), .memRegWrite(memRegWrite),
    .wbDest(wbDest), .wbRegWrite(wbRegWrite), .idRs(idRs), .idRt(idRt),
    .idUseRs(idUseRs), .idUseRt(idUseRt), .exDest(exDest),
    .exRegWrite(exRegWrite), .exIsLoad(exIsLoad),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .loadUseStall(loadUseStall)
  );

  task automatic check(input string req, input logic [1:0] actual, input logic [1:0] expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b", req, actual, expected);
    end
  endtask

  task automatic clearAll();
    exRs = '0; exRt = '0; memDest = '0; wbDest = '0; idRs = '0; idRt = '0; exDest = '0;
    memRegWrite = 0; wbRegWrite = 0; idUseRs = 0; idUseRt = 0; exRegWrite = 0; exIsLoad = 0;
  endtask

  // drive at the falling edge, sample shortly after (purely combinational path)
  task automatic settle();
    #1;
  endtask

  function automatic logic [1:0] modelSel(input logic [AW-1:0] s, input logic [AW-1:0] md,
      input logic mw, input logic [AW-1:0] wd, input logic ww);
    if (s != 0 && mw && s == md) return 2'b10;
    if (s != 0 && ww && s == wd) return 2'b01;
    return 2'b00;
  endfunction

  task automatic testIdle();
    @(negedge clk); clearAll(); settle();
    check("R3 idle A", fwdSelA, 2'b00);
    check("R3 idle B", fwdSelB, 2'b00);
    check("R7 idle stall", {1'b0, loadUseStall}, 2'b00);
  endtask

  task automatic testMemForward();
    @(negedge clk); clearAll();
    exRs = 5'd7; memDest = 5'd7; memRegWrite = 1; settle();
    check("R1 mem bypass A", fwdSelA, 2'b10);
    memRegWrite = 0; settle();
    check("R3 mem disabled", fwdSelA, 2'b00);
  endtask

  task automatic testWbForward();
    @(negedge clk); clearAll();
    exRt = 5'd12; wbDest = 5'd12; wbRegWrite = 1; memDest = 5'd13; memRegWrite = 1; settle();
    check("R2 wb bypass B", fwdSelB, 2'b01);
    check("R2 A untouched", fwdSelA, 2'b00);
  endtask

  task automatic testZeroIndex();
    @(negedge clk); clearAll();
    memRegWrite = 1; wbRegWrite = 1; settle();
    check("R3 zero A", fwdSelA, 2'b00);
    check("R3 zero B", fwdSelB, 2'b00);
  endtask

  task automatic testPriority();
    @(negedge clk); clearAll();
    exRs = 5'd9; memDest = 5'd9; wbDest = 5'd9; memRegWrite = 1; wbRegWrite = 1; settle();
    check("R4 youngest wins", fwdSelA, 2'b10);
  endtask

  task automatic testIndependent();
    @(negedge clk); clearAll();
    exRs = 5'd3; exRt = 5'd4; memDest = 5'd4; wbDest = 5'd3;
    memRegWrite = 1; wbRegWrite = 1; settle();
    check("R5 A from wb", fwdSelA, 2'b01);
    check("R5 B from mem", fwdSelB, 2'b10);
    exRt = 5'd3; settle();
    check("R5 both wb", fwdSelB, 2'b01);
  endtask

  task automatic testLoadUse();
    @(negedge clk); clearAll();
    exIsLoad = 1; exRegWrite = 1; exDest = 5'd6; idRt = 5'd6; idUseRt = 1; settle();
    check("R6 stall on rt", {1'b0, loadUseStall}, 2'b01);
    idRt = 5'd0; idRs = 5'd6; idUseRs = 1; settle();
    check("R6 stall on rs", {1'b0, loadUseStall}, 2'b01);
  endtask

  task automatic testNoStall();
    @(negedge clk); clearAll();
    exIsLoad = 1; exRegWrite = 1; exDest = 5'd6; idRs = 5'd6; idUseRs = 0; settle();
    check("R7 unused source", {1'b0, loadUseStall}, 2'b00);
    idUseRs = 1; exIsLoad = 0; settle();
    check("R7 not a load", {1'b0, loadUseStall}, 2'b00);
    exIsLoad = 1; exRegWrite = 0; settle();
    check("R7 no write", {1'b0, loadUseStall}, 2'b00);
    exRegWrite = 1; exDest = 5'd0; idRs = 5'd0; settle();
    check("R7 zero dest", {1'b0, loadUseStall}, 2'b00);
  endtask

  task automatic testCombined();
    @(negedge clk); clearAll();
    exIsLoad = 1; exRegWrite = 1; exDest = 5'd20; idRs = 5'd20; idUseRs = 1;
    exRs = 5'd21; exRt = 5'd22; memDest = 5'd21; wbDest = 5'd22;
    memRegWrite = 1; wbRegWrite = 1; settle();
    check("R8 stall with bypass", {1'b0, loadUseStall}, 2'b01);
    check("R8 A mem", fwdSelA, 2'b10);
    check("R8 B wb", fwdSelB, 2'b01);
  endtask

  task automatic testSweep();
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 4; w++)
          for (int en = 0; en < 4; en++) begin
            @(negedge clk); clearAll();
            exRs = AW'(s); exRt = AW'(3 - s); memDest = AW'(m); wbDest = AW'(w);
            memRegWrite = en[0]; wbRegWrite = en[1]; settle();
            check("R1 R2 R3 R4 sweep A", fwdSelA, modelSel(exRs, memDest, en[0], wbDest, en[1]));
            check("R5 sweep B", fwdSelB, modelSel(exRt, memDest, en[0], wbDest, en[1]));
          end
  endtask

  initial begin
    clearAll();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    testIdle();
    testMemForward();
    testWbForward();
    testZeroIndex();
    testPriority();
    testIndependent();
    testLoadUse();
    testNoStall();
    testCombined();
    testSweep();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule